// File: doc/BRIEF.md
# Programmable 8-input interrupt controller

This block gathers eight interrupt lines, decides which of them the processor should service next, and returns a byte-wide vector when the processor acknowledges. Software reaches it through a byte port with two addresses. Address 0 takes command words and returns status. Address 1 takes configuration and mask words and returns the mask. Internally it keeps a request register, an in-service register and a mask register. The priority order can be rotated, and the current in-service state blocks requests of equal or lower priority. The block can detect rising edges or follow levels, and it can end interrupts automatically.

Configuration starts with an initialization command at address 0. The data-port writes that follow are consumed in order as configuration words. After that, data-port writes update the mask. Three cascade pins let two instances work as a pair. The master reports on the pins which of its inputs carries a slave. The slave answers an acknowledge only when the pins carry its own identity number.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF (every input blocked), the request and in-service registers are 0, `int_out` is low, and address 0 reads the request register.
- R2: A command write with bit 4 set starts initialization. Its bit 0 requests a mode word, bit 1 marks single operation (no cascade word), and bit 3 selects level triggering. It clears the mask, request and in-service registers, sets input 7 as lowest priority and selects the request register for status reads. The data writes that follow are taken, in order, as the vector base, the cascade word (unless single), the mode word (if requested), and after that as mask writes.
- R3: The acknowledge vector is {base[7:3], input[2:0]}. A mask bit of 1 blocks its input from `int_out` and from acknowledge, but the request is still latched. Data-port reads return the mask.
- R4: Priority runs from the input just above the lowest one and wraps around (default 0 highest, 7 lowest). A request is blocked while an in-service bit of equal or higher priority is set.
- R5: In edge mode a request is latched on a rising edge. It is cleared by acknowledge and needs a new rising edge before it is requested again. In level mode the request follows the line. In both modes a line that falls before acknowledge withdraws its request.
- R6: Command 0x20 clears the highest-priority in-service bit. Command 0x60|n clears in-service bit n.
- R7: Command 0xC0|n makes input n the lowest priority. Command 0xA0 clears the highest-priority in-service bit and makes that input the lowest. Command 0xE0|n clears bit n and makes n the lowest.
- R8: A command with bit 4 = 0 and bit 3 = 1 is a read-select word. When its bit 1 is 1, bit 0 picks the in-service register (1) or the request register (0) for address-0 reads. When bit 1 is 0 the selection is unchanged.
- R9: When mode-word bit 1 (automatic end) is set, an acknowledge does not set any in-service bit.
- R10: An acknowledge with no eligible request delivers {base[7:3], 3'b111} and leaves the in-service register unchanged.
- R11: Mode-word bit 2 selects master (1) or slave (0). On a master, a cascade-word bit of 1 marks an input that has a slave. When such an input wins an acknowledge, the master drives its number on `cas_out` with `cas_oe` high during that acknowledge cycle, sets its in-service bit and delivers no vector. A slave answers an acknowledge only when `cas_in` equals bits 2:0 of its cascade word.
- R12: With mode-word bit 4 (special nesting) set on a master, a slave-bearing input may be requested again while its own in-service bit is set.
- R13: With mode-word bit 3 (buffered) set, `buf_en` is high exactly while a vector is delivered.
- R14: `vec_valid` pulses for one cycle on the clock after the acknowledge cycle. The in-service update takes effect on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = command/status, 1 = data/mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq_lines | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge pulse |
| vec_out | output | 8 | Delivered vector |
| vec_valid | output | 1 | Vector valid pulse |
| buf_en | output | 1 | Buffer enable while a vector is driven |
| cas_in | input | 3 | Cascade identity seen by a slave |
| cas_out | output | 3 | Cascade identity driven by a master |
| cas_oe | output | 1 | Cascade identity valid |

## Verification
The bench checks that the in-service register blocks an input of equal priority: a design that compared strictly would re-raise `int_out` for the input already in service. A request that is withdrawn before acknowledge must give vector base+7 with no in-service bit set. A design that latched the request forever would deliver the real input, and one that marked bit 7 would leave the processor stuck in service. Rotation is checked by acknowledging three simultaneous requests after moving the lowest priority, and by a rotate-on-end command, so a fixed priority encoder would return the wrong order. Slave selection by `cas_in`, re-entry under special nesting, and the skipping of optional configuration words are each checked at the ports, so a design that miscounted the configuration words would take the mask as a configuration word and misplace the vector base.

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  input  logic [DW-1:0]         irq_lines,
  output logic                  int_out,
  input  logic                  int_ack,
  output logic [DW-1:0]         vec_out,
  output logic                  vec_valid,
  output logic                  buf_en,
  input  logic [$clog2(DW)-1:0] cas_in,
  output logic [$clog2(DW)-1:0] cas_out,
  output logic                  cas_oe
);
  localparam int IW = $clog2(DW);

  typedef enum logic [1:0] {CFG_RUN, CFG_BASE, CFG_CASC, CFG_MODE} cfg_t;

  cfg_t st;
  logic need_mode, single, level_mode, aeoi, is_master, bufm, sfnm, sel_isr;
  logic [DW-IW-1:0] base_hi;
  logic [DW-1:0] casc_r, mask_r, irr, isr, line_q, casc_map, irr_n, isr_n;
  logic [IW-1:0] low_r, low_n, top_idx, top_rank, win_idx, op_n;
  logic isr_any, win_any, respond, to_slave, take, spur;
  logic cmd_w, dat_w, icw1, ocw2, ocw3;

  function automatic logic [IW-1:0] at_rank(input logic [IW-1:0] lo, input int k);
    return lo + IW'(k) + IW'(1);
  endfunction

  assign cmd_w = reg_wr & ~reg_addr;
  assign dat_w = reg_wr & reg_addr;
  assign icw1  = cmd_w & reg_wdata[4];
  assign ocw3  = cmd_w & ~reg_wdata[4] & reg_wdata[3];
  assign ocw2  = cmd_w & ~reg_wdata[4] & ~reg_wdata[3];
  assign op_n  = reg_wdata[IW-1:0];
  assign casc_map = (is_master && !single) ? casc_r : '0;

  always_comb begin
    isr_any  = 1'b0;
    top_idx  = '0;
    top_rank = '0;
    for (int k = 0; k < DW; k++) begin
      if (!isr_any && isr[at_rank(low_r, k)]) begin
        isr_any  = 1'b1;
        top_idx  = at_rank(low_r, k);
        top_rank = IW'(k);
      end
    end
  end

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    for (int k = 0; k < DW; k++) begin
      if (!win_any && irr[at_rank(low_r, k)] && !mask_r[at_rank(low_r, k)] &&
          (!isr_any || IW'(k) < top_rank ||
           (sfnm && casc_map[at_rank(low_r, k)] && at_rank(low_r, k) == top_idx))) begin
        win_any = 1'b1;
        win_idx = at_rank(low_r, k);
      end
    end
  end

  assign respond  = is_master | single | (cas_in == casc_r[IW-1:0]);
  assign to_slave = win_any & casc_map[win_idx];
  assign take     = int_ack & respond & win_any;
  assign spur     = int_ack & respond & ~win_any;
  assign int_out  = win_any;
  assign cas_oe   = int_ack & to_slave;
  assign cas_out  = to_slave ? win_idx : '0;
  assign buf_en   = bufm & vec_valid;
  assign reg_rdata = reg_addr ? mask_r : (sel_isr ? isr : irr);

  always_comb begin
    irr_n = level_mode ? irq_lines : (irq_lines & (irr | ~line_q));
    isr_n = isr;
    low_n = low_r;
    if (take) begin
      if (!level_mode) irr_n[win_idx] = 1'b0;
      if (!aeoi) isr_n[win_idx] = 1'b1;
    end
    if (ocw2) begin
      case (reg_wdata[DW-1:DW-3])
        3'b001: if (isr_any) isr_n[top_idx] = 1'b0;
        3'b101: if (isr_any) begin
          isr_n[top_idx] = 1'b0;
          low_n = top_idx;
        end
        3'b011: isr_n[op_n] = 1'b0;
        3'b111: begin
          isr_n[op_n] = 1'b0;
          low_n = op_n;
        end
        3'b110: low_n = op_n;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= CFG_RUN;
      need_mode  <= 1'b0;
      single     <= 1'b1;
      level_mode <= 1'b0;
      aeoi       <= 1'b0;
      is_master  <= 1'b1;
      bufm       <= 1'b0;
      sfnm       <= 1'b0;
      sel_isr    <= 1'b0;
      base_hi    <= '0;
      casc_r     <= '0;
      mask_r     <= '1;
      irr        <= '0;
      isr        <= '0;
      line_q     <= '0;
      low_r      <= IW'(DW-1);
      vec_out    <= '0;
      vec_valid  <= 1'b0;
    end else begin
      line_q    <= irq_lines;
      irr       <= irr_n;
      isr       <= isr_n;
      low_r     <= low_n;
      vec_valid <= (take & ~to_slave) | spur;
      if (take && !to_slave) vec_out <= {base_hi, win_idx};
      else if (spur)         vec_out <= {base_hi, {IW{1'b1}}};
      if (ocw3 && reg_wdata[1]) sel_isr <= reg_wdata[0];
      if (icw1) begin
        st         <= CFG_BASE;
        level_mode <= reg_wdata[3];
        single     <= reg_wdata[1];
        need_mode  <= reg_wdata[0];
        aeoi       <= 1'b0;
        is_master  <= 1'b1;
        bufm       <= 1'b0;
        sfnm       <= 1'b0;
        sel_isr    <= 1'b0;
        casc_r     <= '0;
        mask_r     <= '0;
        irr        <= '0;
        isr        <= '0;
        low_r      <= IW'(DW-1);
      end else if (dat_w) begin
        case (st)
          CFG_BASE: begin
            base_hi <= reg_wdata[DW-1:IW];
            st <= !single ? CFG_CASC : (need_mode ? CFG_MODE : CFG_RUN);
          end
          CFG_CASC: begin
            casc_r <= reg_wdata;
            st <= need_mode ? CFG_MODE : CFG_RUN;
          end
          CFG_MODE: begin
            aeoi      <= reg_wdata[1];
            is_master <= reg_wdata[2];
            bufm      <= reg_wdata[3];
            sfnm      <= reg_wdata[4];
            st        <= CFG_RUN;
          end
          default: mask_r <= reg_wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          int_ack,
  input logic          int_out,
  input logic          vec_valid,
  input logic [DW-1:0] vec_out,
  input logic          cas_oe,
  input logic [DW-1:0] mask_r,
  input logic [DW-1:0] irr,
  input logic [DW-1:0] isr,
  input logic          aeoi,
  input logic          sfnm,
  input logic          is_master
);
  localparam int IW = $clog2(DW);

  p_req_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> |(irr & ~mask_r));

  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[4]) |=> (mask_r == '0 && isr == '0 && irr == '0));

  p_ack_marks_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_out && is_master && !aeoi && !sfnm && !reg_wr) |=> |(isr & ~$past(isr)));

  p_auto_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && aeoi && !reg_wr) |=> $stable(isr));

  p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && is_master && !int_out && !reg_wr) |=>
      (vec_valid && (&vec_out[IW-1:0]) && $stable(isr)));

  p_cascade_no_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cas_oe |=> !vec_valid);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .int_ack(int_ack), .int_out(int_out),
  .vec_valid(vec_valid), .vec_out(vec_out), .cas_oe(cas_oe),
  .mask_r(mask_r), .irr(irr), .isr(isr), .aeoi(aeoi), .sfnm(sfnm),
  .is_master(is_master)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam time TCK = 20ns;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0, int_ack = 1'b0;
  logic [7:0] reg_wdata = '0, irq_lines = '0;
  logic [2:0] cas_in = '0;
  logic [7:0] reg_rdata, vec_out;
  logic [2:0] cas_out;
  logic int_out, vec_valid, buf_en, cas_oe;
  int errors = 0, checks = 0;

  logic a_oe, a_vv, a_be;
  logic [2:0] a_cas;
  logic [7:0] a_vec, rv;

  always #(TCK/2) clk = ~clk;

  prio_irq_ctrl #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
    .int_out(int_out), .int_ack(int_ack), .vec_out(vec_out),
    .vec_valid(vec_valid), .buf_en(buf_en), .cas_in(cas_in),
    .cas_out(cas_out), .cas_oe(cas_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk);
    irq_lines = v;
    @(negedge clk);
  endtask

  task automatic ack(input logic [2:0] c);
    @(negedge clk);
    int_ack = 1'b1; cas_in = c;
    #1 a_oe = cas_oe; a_cas = cas_out;
    @(negedge clk);
    int_ack = 1'b0;
    #1 a_vv = vec_valid; a_vec = vec_out; a_be = buf_en;
  endtask

  task automatic init(input logic [7:0] w1, input logic [7:0] base,
                      input logic [7:0] casc, input logic [7:0] mode);
    lines(8'h00);
    wr(1'b0, w1);
    wr(1'b1, base);
    if (!w1[1]) wr(1'b1, casc);
    if (w1[0]) wr(1'b1, mode);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_reset;
    #1 chk("R1 int_out", int_out, 0);
    rd(1'b1, rv); chk("R1 mask", rv, 8'hFF);
    rd(1'b0, rv); chk("R1 irr", rv, 8'h00);
  endtask

  task automatic t_basic;
    init(8'h13, 8'h48, 8'h00, 8'h05);
    lines(8'h08);
    chk("R5 edge raise", int_out, 1);
    ack(3'd0);
    chk("R14 valid", a_vv, 1);
    chk("R3 vector", a_vec, 8'h4B);
    chk("R13 no buf", a_be, 0);
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk("R14 isr set", rv, 8'h08);
    chk("R4 equal blocked", int_out, 0);
    wr(1'b0, 8'h20);
    rd(1'b0, rv); chk("R6 ns eoi", rv, 8'h00);
    chk("R5 no new edge", int_out, 0);
    rd(1'b1, rv); chk("R3 mask read", rv, 8'h00);
  endtask

  task automatic t_mask;
    init(8'h13, 8'h48, 8'h00, 8'h05);
    wr(1'b1, 8'hFF);
    lines(8'h20);
    chk("R3 masked", int_out, 0);
    rd(1'b0, rv); chk("R3 latched irr", rv, 8'h20);
    wr(1'b1, 8'hDF);
    #1 chk("R3 unmasked", int_out, 1);
    ack(3'd0);
    chk("R3 vec5", a_vec, 8'h4D);
  endtask

  task automatic t_nested;
    init(8'h13, 8'h80, 8'h00, 8'h05);
    lines(8'h40);
    ack(3'd0); chk("R4 vec6", a_vec, 8'h86);
    lines(8'h44);
    chk("R4 higher preempts", int_out, 1);
    ack(3'd0); chk("R4 vec2", a_vec, 8'h82);
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk("R4 nested isr", rv, 8'h44);
    lines(8'h04);
    lines(8'hC4);
    chk("R4 lower blocked", int_out, 0);
    wr(1'b0, 8'h20);
    rd(1'b0, rv); chk("R6 clears top", rv, 8'h40);
    chk("R4 still blocked", int_out, 0);
    wr(1'b0, 8'h66);
    rd(1'b0, rv); chk("R6 specific", rv, 8'h00);
    chk("R4 released", int_out, 1);
    ack(3'd0); chk("R4 order 6 before 7", a_vec, 8'h86);
  endtask

  task automatic t_level;
    init(8'h1B, 8'h08, 8'h00, 8'h05);
    lines(8'h02);
    ack(3'd0); chk("R5 level vec", a_vec, 8'h09);
    #1 chk("R5 in service", int_out, 0);
    wr(1'b0, 8'h20);
    #1 chk("R5 level re-request", int_out, 1);
    lines(8'h00);
    chk("R5 level drop", int_out, 0);
  endtask

  task automatic t_rotate;
    init(8'h13, 8'h10, 8'h00, 8'h07);
    wr(1'b0, 8'hC1);
    lines(8'h85);
    ack(3'd0); chk("R7 first 2", a_vec, 8'h12);
    ack(3'd0); chk("R7 then 7", a_vec, 8'h17);
    ack(3'd0); chk("R7 then 0", a_vec, 8'h10);
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk("R9 auto end isr", rv, 8'h00);
    chk("R7 drained", int_out, 0);
  endtask

  task automatic t_rot_eoi;
    init(8'h13, 8'h10, 8'h00, 8'h05);
    lines(8'h08);
    ack(3'd0); chk("R7 vec3", a_vec, 8'h13);
    wr(1'b0, 8'hA0);
    lines(8'h1C);
    ack(3'd0); chk("R7 rotate on eoi", a_vec, 8'h14);
  endtask

  task automatic t_readsel;
    init(8'h13, 8'h30, 8'h00, 8'h05);
    lines(8'h20);
    rd(1'b0, rv); chk("R8 default irr", rv, 8'h20);
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk("R8 isr empty", rv, 8'h00);
    ack(3'd0); chk("R8 vec", a_vec, 8'h35);
    rd(1'b0, rv); chk("R8 isr", rv, 8'h20);
    wr(1'b0, 8'h09);
    rd(1'b0, rv); chk("R8 no enable", rv, 8'h20);
    wr(1'b0, 8'h0A);
    rd(1'b0, rv); chk("R8 back to irr", rv, 8'h00);
  endtask

  task automatic t_spur;
    init(8'h13, 8'h58, 8'h00, 8'h05);
    lines(8'h10);
    chk("R10 raised", int_out, 1);
    lines(8'h00);
    chk("R10 withdrawn", int_out, 0);
    ack(3'd0);
    chk("R10 valid", a_vv, 1);
    chk("R10 vector", a_vec, 8'h5F);
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk("R10 isr clear", rv, 8'h00);
  endtask

  task automatic t_master;
    init(8'h11, 8'h20, 8'h04, 8'h1D);
    lines(8'h04);
    ack(3'd0);
    chk("R11 cas_oe", a_oe, 1);
    chk("R11 cas_out", a_cas, 3'd2);
    chk("R11 no vector", a_vv, 0);
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk("R11 isr", rv, 8'h04);
    lines(8'h00);
    lines(8'h04);
    chk("R12 re-request", int_out, 1);
    ack(3'd0);
    chk("R12 cas again", a_cas, 3'd2);
    lines(8'h05);
    ack(3'd0);
    chk("R11 plain oe", a_oe, 0);
    chk("R11 plain vec", a_vec, 8'h20);
    chk("R13 buf_en", a_be, 1);
  endtask

  task automatic t_slave;
    init(8'h11, 8'h70, 8'h02, 8'h01);
    lines(8'h40);
    chk("R11 slave int", int_out, 1);
    ack(3'd5);
    chk("R11 other id", a_vv, 0);
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk("R11 other id isr", rv, 8'h00);
    ack(3'd2);
    chk("R11 own id", a_vec, 8'h76);
    rd(1'b0, rv); chk("R11 own isr", rv, 8'h40);
  endtask

  task automatic t_reinit;
    lines(8'h00);
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h88);
    wr(1'b1, 8'h3C);
    rd(1'b1, rv); chk("R2 mask after base", rv, 8'h3C);
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk("R2 isr cleared", rv, 8'h00);
    lines(8'h01);
    ack(3'd0); chk("R2 base used", a_vec, 8'h88);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(TCK * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_mask();
    t_nested();
    t_level();
    t_rotate();
    t_rot_eoi();
    t_readsel();
    t_spur();
    t_master();
    t_slave();
    t_reinit();
    summary();
    $finish;
  end
endmodule